// File: doc/BRIEF.md
# Saturating Multi-Rate Timer Bank

A bank of byte-wide countdown timers that are all serviced together in hardware. The timers are divided into three rate tiers: a fast tier that steps on every base tick, a half-rate tier that steps on every second tick, and a quarter-rate tier that steps on every fourth tick. A single free-running two-bit phase counter, advanced by the base tick, decides which tiers step on a given tick. Because every tier is a power of two of the base period, one byte of count can cover long intervals with a resolution of about one part in 128 of the interval.

A client starts a timer by writing a non-zero count to it through a write port (timer index plus value). The timer then counts down on its tier's ticks and stops at zero, never wrapping. As a result "time is up" is simply a zero test, and the block presents it as one expired flag per timer. A read port returns the current count of any selected timer.

Timer indices are laid out by tier: indices `0 .. N_FAST-1` are fast, the next `N_HALF` indices are half-rate, and the last `N_QUAR` indices are quarter-rate.

Top module: `rate_timer_bank`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every timer holds zero, every expired flag is 1 and the phase counter is zero.
- R2: A write with `wr_en_i` high and `wr_idx_i` below the timer count loads `wr_val_i` into that timer at the next clock edge.
- R3: A fast-tier timer that holds a non-zero value and is not written drops by exactly one at every clock edge where `tick_i` is high.
- R4: On each tick the phase counter goes from c to c+1 (mod 4). Half-rate timers step only on ticks where bit 0 of c+1 is 1, that is on the 1st, 3rd, 5th tick after reset.
- R5: Quarter-rate timers step only on ticks where c+1 equals binary 11, that is exactly once in every four ticks (the 3rd, 7th, ... tick after reset).
- R6: A timer that holds zero stays at zero when its tier steps; it never wraps to 255.
- R7: When a write and a step reach the same timer at the same edge, the written value is stored and the step is discarded.
- R8: A write whose index is not below the timer count changes no timer.
- R9: With `tick_i` low and no write, no timer changes.
- R10: `rd_val_o` shows, without a clock delay, the current count of timer `rd_idx_i`. An index not below the timer count reads as zero.
- R11: `expired_o[i]` is 1 exactly when timer i holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base tick, one cycle per base period |
| wr_en_i | input | 1 | Load strobe |
| wr_idx_i | input | IDX_W | Timer to load |
| wr_val_i | input | TW | Count to load |
| rd_idx_i | input | IDX_W | Timer to read |
| rd_val_o | output | TW | Current count of the selected timer |
| expired_o | output | N_FAST+N_HALF+N_QUAR | One flag per timer, 1 when its count is zero |

## Verification
Three timers, one per tier, are loaded with different counts and then ticked in a row from a known phase. The fast timer shows single steps. The half-rate and quarter-rate timers show whether the step lands on the right phase values, because an off-by-one in the phase decode changes which tick they step on. A later run of eight ticks on a quarter-rate timer loaded with 255 tells a rate of one step per four ticks apart from a rate of two, whatever the starting phase. The corner patterns are a timer held at zero while its tier steps, a load on the same edge as a step, an out-of-range write and read, idle cycles, and reset in the middle of a run.

// File: rtl/rtb_pkg.sv
package rtb_pkg;

    typedef enum logic [1:0] {
        TIER_FAST = 2'd0,
        TIER_HALF = 2'd1,
        TIER_QUAR = 2'd2
    } tier_e;

    localparam int NUM_TIERS = 3;
    localparam int PHASE_W   = 2;

    typedef struct packed {
        logic [PHASE_W-1:0] cnt;
    } phase_t;

endpackage

// File: rtl/rtb_phase.sv
module rtb_phase
    import rtb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    output logic [NUM_TIERS-1:0] step_o
);

    phase_t st_q, st_d;
    logic [PHASE_W-1:0] nxt;

    always_comb begin
        st_d = st_q;
        nxt  = PHASE_W'(st_q.cnt + PHASE_W'(1));
        step_o = '0;
        if (tick_i) begin
            st_d.cnt          = nxt;
            step_o[TIER_FAST] = 1'b1;
            step_o[TIER_HALF] = nxt[0];
            step_o[TIER_QUAR] = (nxt == {PHASE_W{1'b1}});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    phase_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> st_q.cnt == PHASE_W'($past(st_q.cnt) + PHASE_W'(1)));

    // R9
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |-> step_o == '0);

    // R5
    quar_in_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o[TIER_QUAR] |-> step_o[TIER_HALF]);

    // R4
    half_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && step_o[TIER_HALF]) |=> (tick_i |-> !step_o[TIER_HALF]));

endmodule

// File: rtl/rtb_cell.sv
module rtb_cell #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          ld_i,
    input  logic [TW-1:0] ld_val_i,
    output logic [TW-1:0] val_o
);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } cell_t;

    cell_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            st_d.cnt = ld_val_i;
        end else if (step_i && (st_q.cnt != '0)) begin
            st_d.cnt = TW'(st_q.cnt - TW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o = st_q.cnt;

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> st_q.cnt == $past(ld_val_i));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && st_q.cnt == '0) |=> st_q.cnt == '0);

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && step_i && st_q.cnt != '0) |=> st_q.cnt == TW'($past(st_q.cnt) - TW'(1)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && !step_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/rate_timer_bank.sv
module rate_timer_bank
    import rtb_pkg::*;
#(
    parameter int TW     = 8,
    parameter int N_FAST = 2,
    parameter int N_HALF = 2,
    parameter int N_QUAR = 2,
    parameter int IDX_W  = $clog2(N_FAST + N_HALF + N_QUAR + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tick_i,
    input  logic                              wr_en_i,
    input  logic [IDX_W-1:0]                  wr_idx_i,
    input  logic [TW-1:0]                     wr_val_i,
    input  logic [IDX_W-1:0]                  rd_idx_i,
    output logic [TW-1:0]                     rd_val_o,
    output logic [N_FAST+N_HALF+N_QUAR-1:0]   expired_o
);

    localparam int NT = N_FAST + N_HALF + N_QUAR;

    function automatic tier_e tier_of(input int idx);
        if (idx < N_FAST)               return TIER_FAST;
        else if (idx < N_FAST + N_HALF) return TIER_HALF;
        else                            return TIER_QUAR;
    endfunction

    logic [NUM_TIERS-1:0]   step;
    logic [NT-1:0][TW-1:0]  vals;
    logic [NT-1:0]          ld;

    rtb_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .step_o (step)
    );

    for (genvar g = 0; g < NT; g++) begin : g_cell
        localparam tier_e TIER = tier_of(g);

        assign ld[g] = wr_en_i && (wr_idx_i == IDX_W'(g));

        rtb_cell #(.TW(TW)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_i   (step[TIER]),
            .ld_i     (ld[g]),
            .ld_val_i (wr_val_i),
            .val_o    (vals[g])
        );

        assign expired_o[g] = (vals[g] == '0);
    end

    always_comb begin
        rd_val_o = '0;
        for (int i = 0; i < NT; i++) begin
            if (rd_idx_i == IDX_W'(i)) rd_val_o = vals[i];
        end
    end

    // R8
    oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (int'(wr_idx_i) >= NT) && !tick_i) |=> $stable(vals));

    // R2
    load_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(wr_idx_i) < NT && wr_val_i != '0)
            |=> !expired_o[$past(wr_idx_i)]);

endmodule

// File: tb/sim_rate_timer_bank.sv
module sim_rate_timer_bank;

    localparam int NT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_idx_i = '0;
    logic [7:0] wr_val_i = '0;
    logic [2:0] rd_idx_i = '0;
    logic [7:0] rd_val_o;
    logic [NT-1:0] expired_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rate_timer_bank u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_val_i(wr_val_i),
        .rd_idx_i(rd_idx_i), .rd_val_o(rd_val_o), .expired_o(expired_o)
    );

    typedef struct packed {
        logic       tk;
        logic       we;
        logic [2:0] wi;
        logic [7:0] wv;
        logic [2:0] ri;
        logic [7:0] ex;
        logic [3:0] rq;
    } vec_t;

    // Timers 0,1 fast; 2,3 half; 4,5 quarter. Phase is 0 after reset.
    localparam vec_t VECS [12] = '{
        '{1'b0, 1'b1, 3'd0, 8'd5, 3'd0, 8'd5, 4'd2},  // R2 load fast
        '{1'b0, 1'b1, 3'd2, 8'd4, 3'd2, 8'd4, 4'd2},  // R2 load half
        '{1'b0, 1'b1, 3'd4, 8'd3, 3'd4, 8'd3, 4'd2},  // R2 load quarter
        '{1'b1, 1'b0, 3'd0, 8'd0, 3'd0, 8'd4, 4'd3},  // R3 tick 1
        '{1'b1, 1'b0, 3'd0, 8'd0, 3'd2, 8'd3, 4'd4},  // R4 tick 2: half idle
        '{1'b1, 1'b0, 3'd0, 8'd0, 3'd4, 8'd2, 4'd5},  // R5 tick 3: quarter steps
        '{1'b1, 1'b0, 3'd0, 8'd0, 3'd2, 8'd2, 4'd4},  // R4 tick 4: half idle
        '{1'b1, 1'b0, 3'd0, 8'd0, 3'd0, 8'd0, 4'd3},  // R3 tick 5: fast hits 0
        '{1'b1, 1'b0, 3'd0, 8'd0, 3'd0, 8'd0, 4'd6},  // R6 tick 6: stays 0
        '{1'b1, 1'b1, 3'd0, 8'd7, 3'd0, 8'd7, 4'd7},  // R7 tick 7 + load
        '{1'b0, 1'b1, 3'd6, 8'd9, 3'd6, 8'd0, 4'd10}, // R10 out-of-range read
        '{1'b0, 1'b0, 3'd0, 8'd0, 3'd2, 8'd0, 4'd4}   // R4 half reached 0 at tick 7
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            4'd10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_exp(input string req, input logic [NT-1:0] exp);
        checks++;
        if (expired_o !== exp) begin
            errors++;
            $display("FAIL %s: expired actual=%b expected=%b", req, expired_o, exp);
        end
    endtask

    // Drive at negedge; the design captures at the posedge in between.
    task automatic cyc(input logic tk, input logic we, input logic [2:0] wi, input logic [7:0] wv);
        tick_i = tk; wr_en_i = we; wr_idx_i = wi; wr_val_i = wv;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [2:0] ri, input logic [7:0] exp);
        rd_idx_i = ri;
        #1;
        check(req, rd_val_o, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check_exp("R1", 6'b111111);
        read_chk("R1", 3'd0, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_exp("R11", 6'b111111);

        foreach (VECS[k]) begin
            cyc(VECS[k].tk, VECS[k].we, VECS[k].wi, VECS[k].wv);
            read_chk(req_name(VECS[k].rq), VECS[k].ri, VECS[k].ex);
        end

        // R11: t0=7, t4=1, others zero
        check_exp("R11", 6'b101110);
        read_chk("R6", 3'd1, 8'd0);

        // R8: out-of-range write changes nothing
        cyc(1'b0, 1'b1, 3'd7, 8'd33);
        check_exp("R8", 6'b101110);
        read_chk("R8", 3'd0, 8'd7);
        read_chk("R8", 3'd4, 8'd1);

        // R9: idle cycles hold everything
        repeat (3) cyc(1'b0, 1'b0, 3'd0, 8'd0);
        read_chk("R9", 3'd0, 8'd7);
        read_chk("R9", 3'd4, 8'd1);

        // R5: quarter tier steps twice in eight ticks
        cyc(1'b0, 1'b1, 3'd5, 8'd255);
        read_chk("R2", 3'd5, 8'd255);
        repeat (8) cyc(1'b1, 1'b0, 3'd0, 8'd0);
        read_chk("R5", 3'd5, 8'd253);
        read_chk("R6", 3'd0, 8'd0);
        read_chk("R4", 3'd2, 8'd0);
        check_exp("R11", 6'b011111);

        // R1: reset in the middle of a run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_exp("R1", 6'b111111);
        read_chk("R1", 3'd5, 8'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule